// File: doc/BRIEF.md
# Dual-Channel Prescaled PWM Generator

This block produces two independent pulse-width-modulated outputs from a single system clock. Software programs it through a small synchronous register port: one shared control word holds a short field group for each channel, and each channel has its own word that packs the period length and the active (high) length. Each channel divides the system clock with a selectable prescaler, counts the divided ticks through one period, and drives its output active while the count is below the programmed duty length.

A new period/duty word does not disturb a running waveform. It is parked in a holding register and moved into the working registers at the next period wrap, so the current period always finishes with the old settings. A per-channel ready flag in the control word tells software that a written value is still waiting. When the channel is disabled, the value is taken over on the following clock.

Top module: `pwm_dual`

## Requirements
- R1: After reset every register reads 0, both channels are disabled with inverted polarity, and both outputs sit at their inactive level, which is 1.
- R2: The control word is at byte address 0x0 and channel n's period/duty word is at 0x4 + 4*n. In the control word, channel n's group starts at bit 15*n: bits [3:0] prescaler code, bit 4 enable, bit 5 polarity, bit 6 clock gate. All other bits read 0 and writes to them are ignored, except the ready bits of R3. Unmapped addresses read 0.
- R3: Control bit 28+n (the ready flag) reads 1 from the clock edge that writes channel n's period/duty word until that value is taken into the working registers. Writes to the ready bits through the control word have no effect.
- R4: Prescaler codes 0,1,2,3,4 divide the clock by 120, 180, 240, 360, 480; codes 8,9,10,11,12 divide by 12000, 24000, 36000, 48000, 72000; code 15 divides by 1. Codes 5, 6, 7, 13, 14 are reserved and deliver no ticks, so the count stays where it is.
- R5: The period/duty word holds period-minus-one in bits [31:16] and duty in bits [15:0]. The count advances once per prescaled tick from 0 to period-minus-one and then returns to 0. The output is active while count < duty.
- R6: A duty of 0 keeps the output inactive for the whole period, and a duty greater than period-minus-one keeps it active for the whole period.
- R7: With the polarity bit at 1 the active level is 1 and the inactive level is 0. With the bit at 0 the active level is 0 and the inactive level is 1.
- R8: The output toggles only while both enable and gate are 1. With enable at 1 and gate at 0 the output is inactive, the count is frozen, and it resumes from the same value when the gate is set again. With enable at 0 the output is inactive and the count and prescaler return to 0, so the next enable starts a fresh period.
- R9: A period/duty word written while the channel is enabled takes effect at the next wrap of the count. When the channel is disabled it takes effect on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | NCH (2) | PWM outputs, one bit per channel |

## Verification
The bench sweeps period and duty through every combination around the edges: a one-tick period, duty 0, duty equal to the period, and duty past the period, in both polarities on each channel. A comparator that is off by one, or one that treats an oversized duty as zero, shows up there as a wrong level in one slot of the period. Each real prescaler code is timed to the exact cycle of its first output edge, which catches a wrong table entry or a divider that runs one cycle slow. It also checks that the reserved codes freeze the count. Separate sequences change the period/duty word in the middle of a period, drop and restore the gate, and disable and re-enable a channel. A design that loads new values at once, clears the ready flag too early, loses the frozen count, or keeps a stale count after disable gives a different waveform or flag value in those sequences.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
// Package: register layout constants and the prescaler divide table shared
// by the PWM generator, its register block and its checker.
package pwm_pkg;
    localparam int CH_STRIDE = 15;   // bit distance between channel groups
    localparam int FIELD_W   = 7;    // writable bits per channel group
    localparam int RDY_BASE  = 28;   // ready flag of channel 0
    localparam int PD_BASE   = 4;    // byte address of channel 0 period/duty
    localparam int PD_STEP   = 4;    // byte distance between channel words
    localparam int CNT_W     = 16;   // period and duty counter width
    localparam int DIV_W     = 17;   // wide enough for the largest divider

    // Divide ratio for a prescaler code; 0 marks a reserved code.
    function automatic logic [DIV_W-1:0] code_div(input logic [3:0] code);
        logic [DIV_W-1:0] r;
        case (code)
            4'd0:    r = DIV_W'(120);
            4'd1:    r = DIV_W'(180);
            4'd2:    r = DIV_W'(240);
            4'd3:    r = DIV_W'(360);
            4'd4:    r = DIV_W'(480);
            4'd8:    r = DIV_W'(12000);
            4'd9:    r = DIV_W'(24000);
            4'd10:   r = DIV_W'(36000);
            4'd11:   r = DIV_W'(48000);
            4'd12:   r = DIV_W'(72000);
            4'd15:   r = DIV_W'(1);
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
// Prescaler: emits a one-cycle tick every code_div(code) clocks while run is
// high. Assumes the code may change at any time; a reserved code stops ticks.
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [3:0] code,
    output logic       tick
);
    logic [DIV_W-1:0] div;
    logic [DIV_W-1:0] pc_q;
    logic             rsv;

    // Decode the divide ratio and produce the tick at the last phase.
    always_comb begin
        div  = code_div(code);
        rsv  = (div == '0);
        tick = run && !rsv && (pc_q >= div - DIV_W'(1));
    end

    // Phase counter: cleared when stopped or on a tick, held on a reserved code.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_q <= '0;
        else if (!run)   pc_q <= '0;
        else if (tick)   pc_q <= '0;
        else if (!rsv)   pc_q <= pc_q + DIV_W'(1);
    end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
// One PWM channel: holding register with ready flag, working period/duty,
// tick counter and output level. Assumes the control fields come from
// registers, so the output is a function of registered state only.
module pwm_channel
    import pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             gate,
    input  logic             act,
    input  logic [3:0]       code,
    input  logic             pd_we,
    input  logic [31:0]      pd_wdata,
    output logic [31:0]      pd_hold,
    output logic             ready,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] prd_m1,
    output logic             pwm_o
);
    logic             run;
    logic             tick;
    logic             wrap;
    logic             load;
    logic [CNT_W-1:0] duty_q;

    assign run = en && gate;

    pwm_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (code),
        .tick  (tick)
    );

    // Wrap and load decisions for the current cycle.
    always_comb begin
        wrap = tick && (cnt >= prd_m1);
        load = ready && (!en || wrap);
    end

    // Holding register and ready flag; a new write takes priority over a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_hold <= '0;
            ready   <= 1'b0;
        end else if (pd_we) begin
            pd_hold <= pd_wdata;
            ready   <= 1'b1;
        end else if (load) begin
            ready   <= 1'b0;
        end
    end

    // Working period/duty registers, taken from the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prd_m1 <= '0;
            duty_q <= '0;
        end else if (load) begin
            prd_m1 <= pd_hold[31:16];
            duty_q <= pd_hold[15:0];
        end
    end

    // Tick counter: zero when disabled, wraps after period-minus-one.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (!en)   cnt <= '0;
        else if (tick)  cnt <= wrap ? '0 : cnt + CNT_W'(1);
    end

    // Output level: active during the duty part of a running channel.
    always_comb begin
        pwm_o = (run && (cnt < duty_q)) ? act : !act;
    end
endmodule

// File: rtl/pwm_ctrl_regs.sv
`timescale 1ns/1ps
// Control register and address decode. Holds the writable field group of
// each channel and strobes the period/duty word writes. Assumes one write
// per cycle and that the caller slices each channel's field bits.
module pwm_ctrl_regs
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NCH-1:0][FIELD_W-1:0]   wfield,
    output logic [NCH-1:0][3:0]           ch_code,
    output logic [NCH-1:0]                ch_en,
    output logic [NCH-1:0]                ch_act,
    output logic [NCH-1:0]                ch_gate,
    output logic [NCH-1:0]                pd_we
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

    logic [NCH-1:0][FIELD_W-1:0] field_q;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // Field group of channel n, written as a whole by a control write.
        always_ff @(posedge clk) begin
            if (!rst_n)                         field_q[n] <= '0;
            else if (we && addr == CTRL_ADDR)   field_q[n] <= wfield[n];
        end

        assign ch_code[n] = field_q[n][3:0];
        assign ch_en[n]   = field_q[n][4];
        assign ch_act[n]  = field_q[n][5];
        assign ch_gate[n] = field_q[n][6];
        assign pd_we[n]   = we && (addr == ADDR_W'(PD_BASE + PD_STEP * n));
    end
endmodule

// File: rtl/pwm_dual.sv
`timescale 1ns/1ps
// Top: multi-channel prescaled PWM generator with a synchronous register
// port. Assumes NCH is 1 or 2 so every channel group and ready flag fits the
// 32-bit control word, and ADDR_W can reach every channel word.
module pwm_dual
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0][FIELD_W-1:0] wfield;
    logic [NCH-1:0][3:0]         ch_code;
    logic [NCH-1:0]              ch_en;
    logic [NCH-1:0]              ch_act;
    logic [NCH-1:0]              ch_gate;
    logic [NCH-1:0]              pd_we;
    logic [NCH-1:0][31:0]        pd_hold;
    logic [NCH-1:0]              ch_ready;
    logic [NCH-1:0][CNT_W-1:0]   ch_cnt;
    logic [NCH-1:0][CNT_W-1:0]   ch_prd;

    for (genvar n = 0; n < NCH; n++) begin : g_slice
        assign wfield[n] = bus_wdata[CH_STRIDE*n +: FIELD_W];
    end

    pwm_ctrl_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (bus_addr),
        .wfield  (wfield),
        .ch_code (ch_code),
        .ch_en   (ch_en),
        .ch_act  (ch_act),
        .ch_gate (ch_gate),
        .pd_we   (pd_we)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        pwm_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (ch_en[n]),
            .gate     (ch_gate[n]),
            .act      (ch_act[n]),
            .code     (ch_code[n]),
            .pd_we    (pd_we[n]),
            .pd_wdata (bus_wdata),
            .pd_hold  (pd_hold[n]),
            .ready    (ch_ready[n]),
            .cnt      (ch_cnt[n]),
            .prd_m1   (ch_prd[n]),
            .pwm_o    (pwm_out[n])
        );
    end

    // Read mux: control word with ready flags, or a channel's holding word.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) begin
            for (int n = 0; n < NCH; n++) begin
                bus_rdata[CH_STRIDE*n +: FIELD_W] =
                    {ch_gate[n], ch_act[n], ch_en[n], ch_code[n]};
                bus_rdata[RDY_BASE + n] = ch_ready[n];
            end
        end
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == ADDR_W'(PD_BASE + PD_STEP * n)) bus_rdata = pd_hold[n];
        end
    end
endmodule

// File: rtl/pwm_dual_chk.sv
`timescale 1ns/1ps
// Checker for pwm_dual: temporal properties over the register fields,
// counters and outputs of each channel. Attached by the bind below.
module pwm_dual_chk
    import pwm_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        bus_we,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic [NCH-1:0]              pwm_out,
    input logic [NCH-1:0][3:0]         ch_code,
    input logic [NCH-1:0]              ch_en,
    input logic [NCH-1:0]              ch_act,
    input logic [NCH-1:0]              ch_gate,
    input logic [NCH-1:0]              ch_ready,
    input logic [NCH-1:0][CNT_W-1:0]   ch_cnt,
    input logic [NCH-1:0][CNT_W-1:0]   ch_prd
);
    for (genvar n = 0; n < NCH; n++) begin : g_chk
        logic rsv;
        assign rsv = (ch_code[n] inside {4'd5, 4'd6, 4'd7, 4'd13, 4'd14});

        // R8
        disabled_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_en[n] |-> pwm_out[n] == !ch_act[n]);

        // R8
        frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[n] && !ch_gate[n] && $past(ch_en[n] && !ch_gate[n]))
            |-> $stable(ch_cnt[n]));

        // R3
        ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_ready[n]) |-> $past(bus_we && bus_addr == ADDR_W'(PD_BASE + PD_STEP * n)));

        // R9
        load_at_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(ch_prd[n]) |-> ch_cnt[n] == '0);

        // R4
        reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_en[n] && rsv && $past(ch_en[n] && rsv)) |-> $stable(ch_cnt[n]));

        // R5
        cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_cnt[n] <= ch_prd[n]);
    end
endmodule

bind pwm_dual pwm_dual_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .pwm_out  (pwm_out),
    .ch_code  (ch_code),
    .ch_en    (ch_en),
    .ch_act   (ch_act),
    .ch_gate  (ch_gate),
    .ch_ready (ch_ready),
    .ch_cnt   (ch_cnt),
    .ch_prd   (ch_prd)
);

// File: tb/tb_pwm_dual.sv
`timescale 1ns/1ps
module tb_pwm_dual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  pwm_out;
    int          n_chk = 0;
    int          n_err = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    pwm_dual dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Called at a negedge; returns at the negedge right after the write edge.
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic exp_lvl(int dv, int p, int d, logic a, int k);
        int c;
        c = (k / dv) % p;
        return (c < d) ? a : !a;
    endfunction

    function automatic int div_of(int code);
        case (code)
            0: return 120;    1: return 180;    2: return 240;
            3: return 360;    4: return 480;    8: return 12000;
            9: return 24000;  10: return 36000; 11: return 48000;
            12: return 72000; default: return 1;
        endcase
    endfunction

    // Runs one channel pair with the given codes; period 2, duty 1, active high.
    task automatic psc_pair(input int ca, input int cb);
        int da, db, mx;
        da = div_of(ca); db = div_of(cb);
        mx = (da > db) ? da : db;
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0001_0001);
        wr(4'h8, 32'h0001_0001);
        step();
        wr(4'h0, (32'(ca) | 32'h70) | ((32'(cb) | 32'h70) << 15));
        for (int k = 0; k <= mx; k++) begin
            if (k == da - 1) check("R4 ch0 before edge", 32'(pwm_out[0]), 32'd1);
            if (k == da)     check("R4 ch0 at edge", 32'(pwm_out[0]), 32'd0);
            if (k == db - 1) check("R4 ch1 before edge", 32'(pwm_out[1]), 32'd1);
            if (k == db)     check("R4 ch1 at edge", 32'(pwm_out[1]), 32'd0);
            step();
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        rd(4'h0, rv); check("R1 ctrl", rv, 32'h0);
        rd(4'h4, rv); check("R1 pd0", rv, 32'h0);
        rd(4'h8, rv); check("R1 pd1", rv, 32'h0);
        check("R1 outputs", 32'(pwm_out), 32'h3);

        // R2: writable field map and ignored bits
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, rv); check("R2 ctrl fields", rv, 32'h003F_807F);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0003_0001);
        rd(4'h4, rv); check("R2 pd0 readback", rv, 32'h0003_0001);
        wr(4'h8, 32'hABCD_1234);
        rd(4'h8, rv); check("R2 pd1 readback", rv, 32'hABCD_1234);
        rd(4'hC, rv); check("R2 unmapped", rv, 32'h0);
        step();

        // R3: ready bits not writable; disabled load clears after one edge
        wr(4'h0, 32'h3000_0000);
        rd(4'h0, rv); check("R3 ready not writable", rv, 32'h0);
        wr(4'h4, 32'h0000_0000);
        rd(4'h0, rv); check("R3 ready set", rv, 32'h1000_0000);
        step();
        rd(4'h0, rv); check("R3 disabled clears", rv, 32'h0);

        // R5 R6 R7 R8: bypass sweep of period, duty and polarity per channel
        for (int ch = 0; ch < 2; ch++) begin
            for (int pm = 0; pm < 5; pm++) begin
                for (int d = 0; d <= pm + 2; d++) begin
                    for (int a = 0; a < 2; a++) begin
                        wr(4'h0, 32'h0);
                        wr(4'(4 + 4 * ch), {16'(pm), 16'(d)});
                        step();
                        wr(4'h0, (32'h5F | (32'(a) << 5)) << (15 * ch));
                        for (int k = 0; k < 2 * (pm + 1) + 2; k++) begin
                            check("R5/R6/R7 sweep level", 32'(pwm_out[ch]),
                                  32'(exp_lvl(1, pm + 1, d, a[0], k)));
                            check("R8 idle channel", 32'(pwm_out[1 - ch]), 32'd1);
                            step();
                        end
                    end
                end
            end
        end

        // R4: every real divider code, two channels at a time
        psc_pair(0, 1);
        psc_pair(2, 3);
        psc_pair(4, 8);
        psc_pair(9, 10);
        psc_pair(11, 12);

        // R4: reserved codes freeze the count at zero (output stays active)
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0001_0001);
        wr(4'h8, 32'h0001_0001);
        step();
        wr(4'h0, 32'h75 | (32'h7D << 15));
        for (int k = 0; k < 300; k++) begin
            if (k == 0 || k == 299) check("R4 reserved hold", 32'(pwm_out), 32'h3);
            step();
        end

        // R9 R3: update while running waits for the wrap
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0003_0001);
        step();
        wr(4'h0, 32'h7F);
        check("R9 old value interval0", 32'(pwm_out[0]), 32'd1);
        wr(4'h4, 32'h0001_0002);
        for (int k = 1; k < 8; k++) begin
            check("R9 level around wrap", 32'(pwm_out[0]), (k < 4) ? 32'd0 : 32'd1);
            rd(4'h0, rv);
            if (k == 1 || k == 3) check("R3 pending while running", 32'(rv[28]), 32'd1);
            if (k == 4)           check("R3 cleared at wrap", 32'(rv[28]), 32'd0);
            step();
        end

        // R8: gate off freezes the count, gate on resumes it
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0003_0002);
        step();
        wr(4'h0, 32'h7F);
        wr(4'h0, 32'h3F);
        for (int k = 0; k < 10; k++) begin
            check("R8 gated inactive", 32'(pwm_out[0]), 32'd0);
            step();
        end
        wr(4'h0, 32'h7F);
        for (int m = 0; m < 5; m++) begin
            check("R8 resume from frozen count", 32'(pwm_out[0]),
                  (m == 1 || m == 2) ? 32'd0 : 32'd1);
            step();
        end

        // R8: disable clears the count; re-enable starts a fresh period
        wr(4'h0, 32'h6F);
        check("R8 disabled inactive", 32'(pwm_out[0]), 32'd0);
        wr(4'h0, 32'h7F);
        for (int k = 0; k < 4; k++) begin
            check("R8 fresh period", 32'(pwm_out[0]), 32'(exp_lvl(1, 4, 2, 1'b1, k)));
            step();
        end

        finish_run();
    end
endmodule